// File: doc/BRIEF.md
# Write-Back Set-Associative Cache with Stamp-Based LRU

This block sits between a single requester and a slower, word-addressed backing memory. The requester issues one read or write at a time on a word address. The cache answers from its own storage when the addressed line is resident. Otherwise it fetches the whole line from memory, after first writing back the line it displaces if that line holds modified data. Each response reports whether the access hit. Two running counters tally hits and misses.

The geometry is set by parameters: 2^SET_BITS sets, WAYS lines per set, and 2^OFF_BITS words per line, over a 2^ADDR_W-word memory. Each line holds a valid flag, a modified flag, a tag, a last-use stamp and its data words. Replacement picks the line whose stamp is oldest. The stamp is a copy of a global count of accepted requests. WAYS = 1 gives a direct-mapped cache.

The memory side is one word per transfer. The cache raises `mem_req` and holds the address, direction and write data until the memory answers with a one-cycle `mem_ack`, which may arrive after any delay.

Top module: `wb_cache`

## Requirements
- R1: An address is split, from most to least significant, into a tag of ADDR_W-SET_BITS-OFF_BITS bits, a set index of SET_BITS bits and a word offset of OFF_BITS bits. A read returns the most recently written value of the addressed word, or its memory value if it was never written.
- R2: A read or write whose tag matches a valid line in the indexed set responds with `rsp_hit` = 1 and causes no memory transfer.
- R3: A write hit updates only the cached word and marks the line modified. No memory write takes place.
- R4: A miss responds with `rsp_hit` = 0. It reads all words of the line from memory, at addresses {tag, set, offset} in ascending offset order starting at offset 0.
- R5: A write miss fetches the whole line first, then merges the written word and marks the line modified.
- R6: The victim on a miss is the lowest-numbered invalid way, if one exists. Otherwise it is the way with the smallest stamp, with ties going to the lowest way.
- R7: A global count increments on every accepted request. The accessed line's stamp is loaded with that count on every hit and every fill.
- R8: A modified victim is written back before the fetch starts. The write-back is all of its words, at {old tag, set, offset} in ascending order. A clean or invalid victim causes no memory write.
- R9: `hit_count` increments once per hit and `miss_count` once per miss. Each changes by at most one per cycle.
- R10: `req_ready` is high only while the cache is idle, so a request is taken when `req_valid` and `req_ready` are both high. `rsp_valid` is a one-cycle pulse, and no memory request is active while it is high.
- R11: Synchronous reset invalidates every line and clears the modified flags and both counters. After reset, `req_ready` is 1 and `mem_req` is 0.
- R12: With WAYS = 1 the same behaviour holds as a direct-mapped cache.
- R13: While `mem_req` is high and no `mem_ack` has arrived, `mem_req`, `mem_we` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access was a hit |
| rsp_rdata | output | DATA_W | Read data (the written value for a write) |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is an eviction of a modified line whose set is full and whose stamps have been shuffled by earlier hits. This is where the stamp comparison, the write-back ordering and the refill meet. The stimulus gets there in several ways. It replays short tag sequences into a single set (A, B, A, C, A, B) so that a recent hit protects one way. It writes into resident lines and then sweeps conflicting tags through every set. It runs a long pseudo-random mix confined to four tags, so that conflicts, modified victims and ties are frequent. A final sweep with unused tags forces every modified line out, and the backing memory is then compared word by word with the expected contents. Both a two-way and a direct-mapped instance run the same sequence.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_EVICT  = 2'd2,
        ST_FILL   = 2'd3
    } cache_state_e;

    // Index width that never collapses to zero bits.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_way_select.sv
module cache_way_select #(
    parameter int WAYS    = 2,
    parameter int TAG_W   = 4,
    parameter int STAMP_W = 16,
    parameter int WAY_W   = 1
) (
    input  logic [WAYS-1:0]             valid_vec,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_vec,
    input  logic [WAYS-1:0][STAMP_W-1:0] stamp_vec,
    input  logic [TAG_W-1:0]            lookup_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            victim_way
);

    // Tag compare for every way, then a lowest-index encoder.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit_vec[w] = valid_vec[w] && (tag_vec[w] == lookup_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    // Victim: the first empty way, or else the oldest stamp (lowest way on ties).
    logic               empty_found;
    logic [STAMP_W-1:0] oldest;

    always_comb begin
        empty_found = 1'b0;
        victim_way  = '0;
        oldest      = stamp_vec[0];
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !empty_found) begin
                empty_found = 1'b1;
                victim_way  = WAY_W'(w);
            end
        end
        if (!empty_found) begin
            for (int w = 1; w < WAYS; w++) begin
                if (stamp_vec[w] < oldest) begin
                    oldest     = stamp_vec[w];
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/cache_stat_counters.sv
module cache_stat_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_hit,
    input  logic             count_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (count_hit)  hit_count  <= hit_count + 1'b1;
            if (count_miss) miss_count <= miss_count + 1'b1;
        end
    end

    // p_one_kind_r9: a single lookup never counts as both hit and miss
    p_one_kind_r9: assert property (@(posedge clk) disable iff (rst)
        !(count_hit && count_miss));

endmodule

// File: rtl/wb_cache.sv
module wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SET_BITS = 2,
    parameter int OFF_BITS = 2,
    parameter int WAYS     = 2,
    parameter int STAMP_W  = 16,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int WORDS = 1 << OFF_BITS;
    localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
    localparam int WAY_W = idx_width(WAYS);

    typedef struct packed {
        logic                write;
        logic [TAG_W-1:0]    tag;
        logic [SET_BITS-1:0] set;
        logic [OFF_BITS-1:0] off;
        logic [DATA_W-1:0]   wdata;
    } cache_req_t;

    // ---------------- line storage ----------------
    logic               line_valid [SETS][WAYS];
    logic               line_dirty [SETS][WAYS];
    logic [TAG_W-1:0]   line_tag   [SETS][WAYS];
    logic [STAMP_W-1:0] line_stamp [SETS][WAYS];
    logic [DATA_W-1:0]  line_data  [SETS][WAYS][WORDS];

    // ---------------- control state ----------------
    cache_state_e        state_q;
    cache_req_t          req_q;
    logic                refill_q;
    logic [WAY_W-1:0]    way_q;
    logic [OFF_BITS-1:0] beat_q;
    logic [STAMP_W-1:0]  access_cnt_q;
    logic                rsp_valid_q;
    logic                rsp_hit_q;
    logic [DATA_W-1:0]   rsp_rdata_q;

    // ---------------- set view for the selector ----------------
    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0][TAG_W-1:0]   set_tags;
    logic [WAYS-1:0][STAMP_W-1:0] set_stamps;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w]  = line_valid[req_q.set][w];
            set_tags[w]   = line_tag[req_q.set][w];
            set_stamps[w] = line_stamp[req_q.set][w];
        end
    end

    cache_way_select #(
        .WAYS    (WAYS),
        .TAG_W   (TAG_W),
        .STAMP_W (STAMP_W),
        .WAY_W   (WAY_W)
    ) u_select (
        .valid_vec  (set_valid),
        .tag_vec    (set_tags),
        .stamp_vec  (set_stamps),
        .lookup_tag (req_q.tag),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    logic in_lookup, lookup_hit, lookup_miss, beat_last, victim_dirty;
    assign in_lookup    = (state_q == ST_LOOKUP);
    assign lookup_hit   = in_lookup && hit;
    assign lookup_miss  = in_lookup && !hit;
    assign beat_last    = (beat_q == OFF_BITS'(WORDS - 1));
    assign victim_dirty = line_valid[req_q.set][victim_way] && line_dirty[req_q.set][victim_way];

    // ---------------- controller with valid/dirty state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            req_q        <= '0;
            refill_q     <= 1'b0;
            way_q        <= '0;
            beat_q       <= '0;
            access_cnt_q <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_hit_q    <= 1'b0;
            rsp_rdata_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    line_valid[s][w] <= 1'b0;
                    line_dirty[s][w] <= 1'b0;
                end
            end
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.write  <= req_write;
                        req_q.tag    <= req_addr[ADDR_W-1 -: TAG_W];
                        req_q.set    <= req_addr[OFF_BITS +: SET_BITS];
                        req_q.off    <= req_addr[OFF_BITS-1:0];
                        req_q.wdata  <= req_wdata;
                        access_cnt_q <= access_cnt_q + 1'b1;
                        refill_q     <= 1'b0;
                        state_q      <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        if (req_q.write) line_dirty[req_q.set][hit_way] <= 1'b1;
                        rsp_rdata_q <= req_q.write ? req_q.wdata
                                                   : line_data[req_q.set][hit_way][req_q.off];
                        rsp_hit_q   <= !refill_q;
                        rsp_valid_q <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        way_q   <= victim_way;
                        beat_q  <= '0;
                        state_q <= victim_dirty ? ST_EVICT : ST_FILL;
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_last) begin
                            line_dirty[req_q.set][way_q] <= 1'b0;
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    line_valid[req_q.set][way_q] <= 1'b0;
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_last) begin
                            line_valid[req_q.set][way_q] <= 1'b1;
                            line_dirty[req_q.set][way_q] <= 1'b0;
                            refill_q <= 1'b1;
                            state_q  <= ST_LOOKUP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- tags, stamps and data (no reset needed) ----------------
    always_ff @(posedge clk) begin
        if (lookup_hit) begin
            line_stamp[req_q.set][hit_way] <= access_cnt_q;
            if (req_q.write) line_data[req_q.set][hit_way][req_q.off] <= req_q.wdata;
        end
        if (state_q == ST_FILL && mem_ack) begin
            line_data[req_q.set][way_q][beat_q] <= mem_rdata;
            if (beat_last) line_tag[req_q.set][way_q] <= req_q.tag;
        end
    end

    cache_stat_counters #(.CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .count_hit  (lookup_hit && !refill_q),
        .count_miss (lookup_miss),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // ---------------- outputs ----------------
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_rdata = rsp_rdata_q;

    assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL);
    assign mem_we    = (state_q == ST_EVICT);
    assign mem_addr  = (state_q == ST_EVICT) ? {line_tag[req_q.set][way_q], req_q.set, beat_q}
                                             : {req_q.tag, req_q.set, beat_q};
    assign mem_wdata = line_data[req_q.set][way_q][beat_q];

    // ---------------- assertions ----------------
    // p_busy_after_accept_r10: one access in flight
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // p_rsp_quiet_mem_r10: response never overlaps a memory transfer
    p_rsp_quiet_mem_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req);

    // p_hold_until_ack_r13: memory request stays put until acknowledged
    p_hold_until_ack_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // p_single_match_r2: at most one way matches a tag
    p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
        in_lookup |-> $onehot0(hit_vec));

    // p_hit_no_traffic_r2: a hit goes straight back to idle, no memory transfer
    p_hit_no_traffic_r2: assert property (@(posedge clk) disable iff (rst)
        lookup_hit |=> !mem_req);

    // p_count_step_r9: hit counter moves by at most one per cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        ##1 ($stable(hit_count) || (hit_count == $past(hit_count) + 1'b1)));

endmodule

// File: tb/cache_env.sv
module cache_env #(
    parameter int WAYS = 2
) (
    input  logic clk,
    input  logic rst,
    output int   checks,
    output int   fails,
    output logic done
);

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SB     = 2;
    localparam int OB     = 2;
    localparam int SETS   = 1 << SB;
    localparam int WORDS  = 1 << OB;
    localparam int MEMSZ  = 1 << ADDR_W;

    logic              req_valid, req_ready, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid, rsp_hit;
    logic [DATA_W-1:0] rsp_rdata;
    logic [15:0]       hit_count, miss_count;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    wb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_BITS(SB), .OFF_BITS(OB),
               .WAYS(WAYS), .STAMP_W(16), .CNT_W(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .hit_count(hit_count), .miss_count(miss_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    // ---------------- reference state ----------------
    logic [DATA_W-1:0] mem_model [MEMSZ];
    logic [DATA_W-1:0] shadow    [MEMSZ];
    bit  rv [SETS][WAYS];
    bit  rd [SETS][WAYS];
    int  rt [SETS][WAYS];
    int  rs [SETS][WAYS];
    int  ref_cnt, ref_hits, ref_misses;

    // memory transfer log for the current access
    int  n_wr, n_rd, first_wr, first_rd, dly, target, n_acks;
    bit  order_bad, hold_pending;
    logic [ADDR_W-1:0] hold_addr;
    logic              hold_we;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (ways=%0d) %s: actual=%0h expected=%0h", req, WAYS, what, act, exp);
        end
    endtask

    // ---------------- backing memory with variable latency ----------------
    initial begin
        mem_ack = 0; mem_rdata = '0; dly = 0; target = 1; n_acks = 0; hold_pending = 0;
        hold_addr = '0; hold_we = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (!rst && mem_req) begin
                if (hold_pending) begin
                    chk(mem_addr == hold_addr && mem_we == hold_we, "R13",
                        "request changed before ack", longint'(mem_addr), longint'(hold_addr));
                end
                if (dly < target) begin
                    dly++;
                    hold_pending = 1; hold_addr = mem_addr; hold_we = mem_we;
                end else begin
                    mem_ack = 1;
                    hold_pending = 0;
                    dly = 0;
                    target = (n_acks * 3 + 1) % 4;
                    n_acks++;
                    if (mem_we) begin
                        if (n_rd > 0) order_bad = 1;
                        if (n_wr == 0) first_wr = int'(mem_addr);
                        else if (int'(mem_addr) != first_wr + n_wr) order_bad = 1;
                        mem_model[mem_addr] = mem_wdata;
                        n_wr++;
                    end else begin
                        if (n_rd == 0) first_rd = int'(mem_addr);
                        else if (int'(mem_addr) != first_rd + n_rd) order_bad = 1;
                        mem_rdata = mem_model[mem_addr];
                        n_rd++;
                    end
                end
            end else begin
                hold_pending = 0;
            end
        end
    end

    // ---------------- one access with prediction and checks ----------------
    task automatic access(input bit wr, input int a, input logic [DATA_W-1:0] wd, input string lbl);
        int  st, tg, off, way, vic, vbase;
        bit  exp_hit, exp_wb;
        logic [DATA_W-1:0] exp_rd;
        st  = (a >> OB) % SETS;
        tg  = a >> (OB + SB);
        off = a % WORDS;
        ref_cnt++;
        exp_hit = 0; way = 0;
        for (int w = WAYS - 1; w >= 0; w--) if (rv[st][w] && rt[st][w] == tg) begin exp_hit = 1; way = w; end
        exp_wb = 0; vbase = 0;
        if (!exp_hit) begin
            vic = -1;
            for (int w = 0; w < WAYS; w++) if (!rv[st][w] && vic < 0) vic = w;
            if (vic < 0) begin
                vic = 0;
                for (int w = 1; w < WAYS; w++) if (rs[st][w] < rs[st][vic]) vic = w;
            end
            exp_wb = rv[st][vic] && rd[st][vic];
            vbase  = (rt[st][vic] << (OB + SB)) | (st << OB);
            way = vic;
            rv[st][way] = 1; rd[st][way] = 0; rt[st][way] = tg;
            ref_misses++;
        end else begin
            ref_hits++;
        end
        rs[st][way] = ref_cnt;
        if (wr) begin rd[st][way] = 1; shadow[a] = wd; end
        exp_rd = shadow[a];

        n_wr = 0; n_rd = 0; first_wr = -1; first_rd = -1; order_bad = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R10", "ready low while busy", longint'(req_ready), 0);
        while (!rsp_valid) @(negedge clk);

        chk(rsp_hit == exp_hit, lbl, $sformatf("hit flag @%0h", a), longint'(rsp_hit), longint'(exp_hit));
        if (!wr) chk(rsp_rdata == exp_rd, "R1", $sformatf("read data @%0h", a), longint'(rsp_rdata), longint'(exp_rd));
        chk(n_rd == (exp_hit ? 0 : WORDS), "R4", "fill word count", n_rd, exp_hit ? 0 : WORDS);
        if (!exp_hit) chk(first_rd == (a & ~(WORDS - 1)), "R4", "fill start address", first_rd, a & ~(WORDS - 1));
        chk(n_wr == (exp_wb ? WORDS : 0), (exp_hit && wr) ? "R3" : "R8", "write-back word count", n_wr, exp_wb ? WORDS : 0);
        if (exp_wb) chk(first_wr == vbase, "R8", "write-back start address", first_wr, vbase);
        chk(!order_bad, "R8", "write-back before fill, ascending", order_bad, 0);
        chk(hit_count == 16'(ref_hits) && miss_count == 16'(ref_misses), "R9", "counters",
            {hit_count, miss_count}, {16'(ref_hits), 16'(ref_misses)});
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] x;
        string dm;
        done = 0; checks = 0; fails = 0;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        ref_cnt = 0; ref_hits = 0; ref_misses = 0;
        for (int i = 0; i < MEMSZ; i++) begin
            mem_model[i] = 32'(i * 7 + 32'h1000);
            shadow[i]    = mem_model[i];
        end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin rv[s][w] = 0; rd[s][w] = 0; rt[s][w] = 0; rs[s][w] = 0; end
        dm = (WAYS == 1) ? "R12" : "R6";

        @(negedge clk);
        while (rst) @(negedge clk);
        // R11: reset state
        chk(req_ready == 1, "R11", "ready after reset", longint'(req_ready), 1);
        chk(mem_req == 0 && rsp_valid == 0, "R11", "idle outputs after reset", {mem_req, rsp_valid}, 0);
        chk(hit_count == 0 && miss_count == 0, "R11", "counters after reset", {hit_count, miss_count}, 0);

        // Sequential read sweep: first word of each line misses, the rest hit
        for (int a = 0; a < 64; a++) access(0, a, '0, (a % WORDS == 0) ? "R4" : "R2");

        // LRU ordering within set 1: A B A C A B
        access(0, (1 << 4) | (1 << 2), '0, dm);
        access(0, (2 << 4) | (1 << 2) | 1, '0, dm);
        access(0, (1 << 4) | (1 << 2) | 2, '0, "R7");
        access(0, (3 << 4) | (1 << 2), '0, dm);
        access(0, (1 << 4) | (1 << 2) | 3, '0, "R7");
        access(0, (2 << 4) | (1 << 2), '0, dm);

        // Writes: hit, write-allocate miss, read back, conflicting sweep forces write-back
        access(1, (2 << 4) | (1 << 2) | 2, 32'hA5A5_0001, "R3");
        access(1, (9 << 4) | (2 << 2) | 1, 32'hA5A5_0002, "R5");
        access(0, (9 << 4) | (2 << 2) | 1, '0, "R5");
        for (int t = 10; t < 13; t++)
            for (int s = 0; s < SETS; s++) access(0, (t << 4) | (s << 2), '0, "R8");

        // Pseudo-random mix over four tags
        x = 32'h1234_5678;
        for (int i = 0; i < 500; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            access(x[20], {2'b00, x[17:16], x[11:10], x[9:8]}, x ^ 32'(i), "R2");
        end

        // Flush every modified line with unused tags, then compare memory
        for (int t = 14; t < 16; t++)
            for (int s = 0; s < SETS; s++) access(0, (t << 4) | (s << 2), '0, "R8");
        for (int i = 0; i < MEMSZ; i++)
            chk(mem_model[i] == shadow[i], (WAYS == 1) ? "R12" : "R8",
                $sformatf("memory word %0h after flush", i), longint'(mem_model[i]), longint'(shadow[i]));
        done = 1;
    end

endmodule

// File: tb/sim_wb_cache.sv
module sim_wb_cache;

    logic clk = 0;
    logic rst = 1;
    int   checks_a, fails_a, checks_b, fails_b;
    logic done_a, done_b;
    bit   timed_out = 0;

    always #10 clk = ~clk;  // 50 MHz

    // two-way instance and direct-mapped instance
    cache_env #(.WAYS(2)) env_a (.clk(clk), .rst(rst), .checks(checks_a), .fails(fails_a), .done(done_a));
    cache_env #(.WAYS(1)) env_b (.clk(clk), .rst(rst), .checks(checks_b), .fails(fails_b), .done(done_b));

    initial begin
        int total, bad;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        fork
            begin
                wait (done_a === 1'b1 && done_b === 1'b1);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        total = checks_a + checks_b;
        bad   = fails_a + fails_b;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", total, bad);
        $finish;
    end

endmodule